// File: doc/BRIEF.md
# Streaming Write Allocation Detector

This block sits beside a cache's write path and watches the write requests it receives, each one carrying a start address, a byte count and the line address it falls in. It follows a single write stream. When consecutive writes keep landing exactly where the previous one ended, it adds up the bytes covered. Once enough bytes have been covered, it tells the cache to merge partial writes into whole-line writes. After a longer run, it tells the cache to stop allocating lines and to send whole-line writes straight to the next level. A write that breaks the sequence puts the block back into normal allocation.

The block also holds a small fully associative table of per-line hold counters. While the detector is merging writes, each new line that is written gets a table entry loaded with a hold budget. The cache can ask, for any line, whether its pending write miss should wait a little longer so that more bytes of the line can arrive. Each positive answer uses up one unit of that line's budget. The cache can also drop a line's entry. A separate mode-clear input returns the stream tracker to normal allocation and leaves the table as it is.

Top module: `wstream_alloc_ctl`

## Requirements
- R1: While and after `rst` is high, `coalesce_o` is 0, `allocate_o` is 1 and `dly_hold_o` is 0, and the hold table holds no entries.
- R2: A write whose start address equals the previous write's start address plus its size adds its size to the run byte count. In every other case, and for the first write after reset or mode clear, the comparison is against address 0. When the count becomes strictly greater than CO_LINES*LINE_BYTES, the flags show merging: `coalesce_o`=1 and `allocate_o`=1. A count equal to the threshold does not change the mode.
- R3: When the count becomes strictly greater than NA_LINES*LINE_BYTES, the flags show no-allocate: `coalesce_o`=1 and `allocate_o`=0.
- R4: A write that does not continue the run restarts the count at that write's size, and the mode is recomputed from that count. A single write no larger than a line therefore returns the flags to `coalesce_o`=0 and `allocate_o`=1.
- R5: In no-allocate mode the count stops growing while the run continues, so the mode stays no-allocate however long the run lasts.
- R6: `mode_clr` returns the mode to allocate and clears the count and the expected address to 0. It takes priority over a write in the same cycle, and that write has no effect.
- R7: The flags change only on the clock edge that samples a write or a mode clear. In other cycles they hold their value.
- R8: A write that leaves the mode other than allocate installs its line in the hold table with a budget of DELAY_THRESH, unless that line is already present. A write that leaves the mode at allocate installs nothing.
- R9: A query (`dq_valid`) for a line that is present with a nonzero budget gives `dly_hold_o`=1 on the next cycle and uses up one unit of the budget. Any other query, and a cycle without a query, gives 0.
- R10: A drop (`dc_valid`) removes the matching entry, so later queries for that line give 0. A drop of the line that a write would install in the same cycle stops that install.
- R11: The table has TBL_ENTRIES entries. An install goes to the lowest-numbered free entry. When no entry is free, it replaces the entry chosen by a rotating pointer that starts at 0 and advances by one on each replacement.
- R12: A query answers from the table as it stood before the edge, so a query in the same cycle as its line's install gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_clr | input | 1 | Returns the stream tracker to allocate mode |
| wr_valid | input | 1 | A write request is present |
| wr_addr | input | ADDR_W | Start byte address of the write |
| wr_size | input | SIZE_W | Byte count of the write |
| wr_line | input | LINE_W | Line address that the write targets |
| dq_valid | input | 1 | Hold query is present |
| dq_line | input | LINE_W | Line address being queried |
| dc_valid | input | 1 | Drop request is present |
| dc_line | input | LINE_W | Line address whose entry is dropped |
| coalesce_o | output | 1 | Merge partial writes into whole-line writes |
| allocate_o | output | 1 | Allocate lines for write misses |
| dly_hold_o | output | 1 | Answer to the previous cycle's query |

## Verification
The main function is exercised with an unbroken run of whole-line writes that crosses both thresholds. This run separates a count equal to a threshold from a count that goes past it. A much longer run follows, well past the width of the count, which would expose a counter that wraps instead of freezing. Runs are then broken by jumps and by mode clears, which shows that restarting from the breaking write's size differs from keeping the old count. A long random mix of contiguous and jumping writes of varied sizes follows, together with queries, drops and clears aimed at recently written lines. This mix brings out replacement order and same-cycle conflicts between install, drop and query, and a behavioural model is compared against the outputs on every clock.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  typedef enum logic [1:0] {
    WM_ALLOC   = 2'd0,
    WM_COAL    = 2'd1,
    WM_NOALLOC = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/wsa_stream_track.sv
module wsa_stream_track
  import wsa_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 7,
  parameter int LINE_BYTES = 64,
  parameter int CO_LINES   = 2,
  parameter int NA_LINES   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_clr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  output logic              coalesce_o,
  output logic              allocate_o,
  output logic              install_en_o
);
  localparam int CO_THR = CO_LINES * LINE_BYTES;
  localparam int NA_THR = NA_LINES * LINE_BYTES;
  // room for the frozen count plus two maximal writes
  localparam int CNT_W  = $clog2(NA_THR + 2 * (2 ** SIZE_W) + 1);

  wr_mode_e          mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, sum;
  logic [ADDR_W-1:0] next_q;
  logic              contig;

  always_comb begin
    contig = (wr_addr == next_q);
    sum    = (contig ? cnt_q : '0) + CNT_W'(wr_size);
    if (mode_q == WM_NOALLOC && contig) begin
      // saturated: the run keeps its mode and the count is frozen
      mode_d = WM_NOALLOC;
      cnt_d  = cnt_q;
    end else begin
      cnt_d = sum;
      if (sum > CNT_W'(NA_THR))      mode_d = WM_NOALLOC;
      else if (sum > CNT_W'(CO_THR)) mode_d = WM_COAL;
      else                           mode_d = WM_ALLOC;
    end
  end

  assign install_en_o = wr_valid && !mode_clr && (mode_d != WM_ALLOC);

  always_ff @(posedge clk) begin
    if (rst || mode_clr) begin
      mode_q     <= WM_ALLOC;
      cnt_q      <= '0;
      next_q     <= '0;
      coalesce_o <= 1'b0;
      allocate_o <= 1'b1;
    end else if (wr_valid) begin
      mode_q     <= mode_d;
      cnt_q      <= cnt_d;
      next_q     <= wr_addr + ADDR_W'(wr_size);
      coalesce_o <= (mode_d != WM_ALLOC);
      allocate_o <= (mode_d != WM_NOALLOC);
    end
  end
endmodule

// File: rtl/wsa_dly_entry.sv
module wsa_dly_entry #(
  parameter int LINE_W       = 26,
  parameter int DLY_W        = 2,
  parameter int DELAY_THRESH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_sel,
  input  logic [LINE_W-1:0] ins_line,
  input  logic              q_valid,
  input  logic [LINE_W-1:0] q_line,
  input  logic              c_valid,
  input  logic [LINE_W-1:0] c_line,
  output logic              valid_o,
  output logic              q_hit_o,
  output logic              w_hit_o,
  output logic              armed_o
);
  logic [LINE_W-1:0] line_q;
  logic [DLY_W-1:0]  cnt_q;
  logic              c_hit;

  assign q_hit_o = valid_o && (line_q == q_line);
  assign w_hit_o = valid_o && (line_q == ins_line);
  assign c_hit   = c_valid && valid_o && (line_q == c_line);
  assign armed_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      line_q  <= '0;
      cnt_q   <= '0;
    end else if (ins_sel) begin
      valid_o <= 1'b1;
      line_q  <= ins_line;
      cnt_q   <= DLY_W'(DELAY_THRESH);
    end else if (c_hit) begin
      valid_o <= 1'b0;
    end else if (q_valid && q_hit_o && armed_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wsa_delay_table.sv
module wsa_delay_table #(
  parameter int LINE_W       = 26,
  parameter int TBL_ENTRIES  = 4,
  parameter int DELAY_THRESH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_en,
  input  logic [LINE_W-1:0] ins_line,
  input  logic              q_valid,
  input  logic [LINE_W-1:0] q_line,
  input  logic              c_valid,
  input  logic [LINE_W-1:0] c_line,
  output logic              hold_o
);
  localparam int IDX_W = (TBL_ENTRIES > 1) ? $clog2(TBL_ENTRIES) : 1;
  localparam int DLY_W = $clog2(DELAY_THRESH + 1);

  logic [TBL_ENTRIES-1:0] valid, q_hit, w_hit, armed, ins_sel;
  logic [IDX_W-1:0]       rr_q, free_idx, victim;
  logic                   any_free, ins_req;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = TBL_ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim  = any_free ? free_idx : rr_q;
  assign ins_req = ins_en && !(|w_hit) && !(c_valid && (c_line == ins_line));

  for (genvar g = 0; g < TBL_ENTRIES; g++) begin : g_ent
    assign ins_sel[g] = ins_req && (victim == IDX_W'(g));
    wsa_dly_entry #(
      .LINE_W(LINE_W), .DLY_W(DLY_W), .DELAY_THRESH(DELAY_THRESH)
    ) i_ent (
      .clk     (clk),
      .rst     (rst),
      .ins_sel (ins_sel[g]),
      .ins_line(ins_line),
      .q_valid (q_valid),
      .q_line  (q_line),
      .c_valid (c_valid),
      .c_line  (c_line),
      .valid_o (valid[g]),
      .q_hit_o (q_hit[g]),
      .w_hit_o (w_hit[g]),
      .armed_o (armed[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q   <= '0;
      hold_o <= 1'b0;
    end else begin
      hold_o <= q_valid && |(q_hit & armed);
      if (ins_req && !any_free)
        rr_q <= (rr_q == IDX_W'(TBL_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/wstream_alloc_ctl.sv
module wstream_alloc_ctl #(
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 64,
  parameter int CO_LINES     = 2,
  parameter int NA_LINES     = 4,
  parameter int DELAY_THRESH = 3,
  parameter int TBL_ENTRIES  = 4,
  parameter int SIZE_W       = $clog2(LINE_BYTES) + 1,
  parameter int LINE_W       = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_clr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              dq_valid,
  input  logic [LINE_W-1:0] dq_line,
  input  logic              dc_valid,
  input  logic [LINE_W-1:0] dc_line,
  output logic              coalesce_o,
  output logic              allocate_o,
  output logic              dly_hold_o
);
  logic install_en;

  wsa_stream_track #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES),
    .CO_LINES(CO_LINES), .NA_LINES(NA_LINES)
  ) i_track (
    .clk         (clk),
    .rst         (rst),
    .mode_clr    (mode_clr),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_size     (wr_size),
    .coalesce_o  (coalesce_o),
    .allocate_o  (allocate_o),
    .install_en_o(install_en)
  );

  wsa_delay_table #(
    .LINE_W(LINE_W), .TBL_ENTRIES(TBL_ENTRIES), .DELAY_THRESH(DELAY_THRESH)
  ) i_table (
    .clk     (clk),
    .rst     (rst),
    .ins_en  (install_en),
    .ins_line(wr_line),
    .q_valid (dq_valid),
    .q_line  (dq_line),
    .c_valid (dc_valid),
    .c_line  (dc_line),
    .hold_o  (dly_hold_o)
  );
endmodule

// File: rtl/wsa_checker.sv
module wsa_checker (
  input logic clk,
  input logic rst,
  input logic mode_clr,
  input logic wr_valid,
  input logic dq_valid,
  input logic coalesce_o,
  input logic allocate_o,
  input logic dly_hold_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!coalesce_o && allocate_o && !dly_hold_o));

  // R3
  flag_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (allocate_o || coalesce_o));

  // R3
  noalloc_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(allocate_o) |-> $past(wr_valid));

  // R6
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_clr |=> (!coalesce_o && allocate_o));

  // R7
  flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid && !mode_clr) |=> ($stable(coalesce_o) && $stable(allocate_o)));

  // R9
  hold_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dly_hold_o |-> $past(dq_valid));
endmodule

bind wstream_alloc_ctl wsa_checker i_wsa_checker (
  .clk       (clk),
  .rst       (rst),
  .mode_clr  (mode_clr),
  .wr_valid  (wr_valid),
  .dq_valid  (dq_valid),
  .coalesce_o(coalesce_o),
  .allocate_o(allocate_o),
  .dly_hold_o(dly_hold_o)
);

// File: tb/test_wstream_alloc_ctl.sv
module test_wstream_alloc_ctl;
  localparam int ADDR_W = 32, LB = 64, COL = 2, NAL = 4, DLY = 3, TBL = 4;
  localparam int SIZE_W = $clog2(LB) + 1;
  localparam int LINE_W = ADDR_W - $clog2(LB);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, mode_clr = 1'b0, wr_valid = 1'b0, dq_valid = 1'b0, dc_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [SIZE_W-1:0] wr_size = '0;
  logic [LINE_W-1:0] wr_line = '0, dq_line = '0, dc_line = '0;
  logic coalesce_o, allocate_o, dly_hold_o;

  wstream_alloc_ctl #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .CO_LINES(COL), .NA_LINES(NAL),
                      .DELAY_THRESH(DLY), .TBL_ENTRIES(TBL)) i_wstream_alloc_ctl (.*);

  int total = 0, bad = 0;
  string phase = "R1";

  // behavioural model
  logic [31:0] m_next;
  int m_cnt, m_mode, m_rr;
  bit m_hold;
  bit m_v[TBL];
  int unsigned m_line[TBL];
  int m_c[TBL];

  function automatic void model_step();
    int qh, fr, tgt, sum, nm;
    bit present, inst;
    if (rst) begin
      m_next = 0; m_cnt = 0; m_mode = 0; m_rr = 0; m_hold = 0;
      for (int i = 0; i < TBL; i++) begin m_v[i] = 0; m_c[i] = 0; m_line[i] = 0; end
      return;
    end
    inst = 0;
    if (mode_clr) begin
      m_next = 0; m_cnt = 0; m_mode = 0;
    end else if (wr_valid) begin
      if (m_mode == 2 && wr_addr == m_next) nm = 2;
      else begin
        sum = (wr_addr == m_next) ? m_cnt + int'(wr_size) : int'(wr_size);
        m_cnt = sum;
        nm = (sum > NAL * LB) ? 2 : (sum > COL * LB) ? 1 : 0;
      end
      m_next = wr_addr + 32'(wr_size);
      m_mode = nm;
      inst = (nm != 0);
    end
    qh = -1; fr = -1; present = 0;
    for (int i = TBL - 1; i >= 0; i--) begin
      if (m_v[i] && m_line[i] == dq_line) qh = i;
      if (m_v[i] && m_line[i] == wr_line) present = 1;
      if (!m_v[i]) fr = i;
    end
    inst = inst && !present && !(dc_valid && dc_line == wr_line);
    m_hold = dq_valid && qh >= 0 && m_c[qh] > 0;
    if (m_hold) m_c[qh]--;
    if (dc_valid)
      for (int i = 0; i < TBL; i++) if (m_v[i] && m_line[i] == dc_line) m_v[i] = 0;
    if (inst) begin
      if (fr >= 0) tgt = fr;
      else begin tgt = m_rr; m_rr = (m_rr + 1) % TBL; end
      m_v[tgt] = 1; m_line[tgt] = wr_line; m_c[tgt] = DLY;
    end
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    chk({phase, " coalesce"}, int'(coalesce_o), int'(m_mode != 0));
    chk({phase, " allocate"}, int'(allocate_o), int'(m_mode != 2));
    chk({phase, " hold"}, int'(dly_hold_o), int'(m_hold));
  endtask

  task automatic idle_inputs();
    wr_valid = 0; dq_valid = 0; dc_valid = 0; mode_clr = 0;
  endtask

  task automatic wr(logic [31:0] a, int sz);
    wr_valid = 1; wr_addr = a; wr_size = SIZE_W'(sz); wr_line = LINE_W'(a >> 6);
    tick(); idle_inputs();
  endtask

  task automatic query(int unsigned ln);
    dq_valid = 1; dq_line = LINE_W'(ln);
    tick(); idle_inputs();
  endtask

  task automatic drop(int unsigned ln);
    dc_valid = 1; dc_line = LINE_W'(ln);
    tick(); idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] cur;
    rst = 1; repeat (3) tick(); rst = 0;
    chk("R1 coalesce", int'(coalesce_o), 0);
    chk("R1 allocate", int'(allocate_o), 1);
    chk("R1 hold", int'(dly_hold_o), 0);

    phase = "R2";
    wr(32'h1000, 64); wr(32'h1040, 64);
    chk("R2 equal threshold", int'(coalesce_o), 0);
    wr(32'h1080, 64);
    chk("R2 coalesce", int'(coalesce_o), 1);
    chk("R2 allocate", int'(allocate_o), 1);
    phase = "R3";
    wr(32'h10C0, 64);
    chk("R3 equal threshold", int'(allocate_o), 1);
    wr(32'h1100, 64);
    chk("R3 no-allocate", int'(allocate_o), 0);
    chk("R3 coalesce", int'(coalesce_o), 1);

    phase = "R9";  // R8: line 0x42 installed by the third write
    query(32'h42); chk("R9 hold 1", int'(dly_hold_o), 1);
    query(32'h42); chk("R9 hold 2", int'(dly_hold_o), 1);
    query(32'h42); chk("R9 hold 3", int'(dly_hold_o), 1);
    query(32'h42); chk("R9 budget spent", int'(dly_hold_o), 0);
    phase = "R10";
    drop(32'h43); query(32'h43); chk("R10 dropped", int'(dly_hold_o), 0);

    phase = "R5";
    cur = 32'h1140;
    for (int i = 0; i < 40; i++) begin wr(cur, 64); cur += 64; end
    chk("R5 stays no-allocate", int'(allocate_o), 0);

    phase = "R4";
    wr(32'h9000, 16);
    chk("R4 coalesce", int'(coalesce_o), 0);
    chk("R4 allocate", int'(allocate_o), 1);
    phase = "R8";
    query(32'h240); chk("R8 no install in allocate", int'(dly_hold_o), 0);

    phase = "R6";
    wr(32'h9010, 64); wr(32'h9050, 64);
    chk("R6 setup coalesce", int'(coalesce_o), 1);
    mode_clr = 1; wr_valid = 1; wr_addr = 32'h9090; wr_size = 64; wr_line = LINE_W'(32'h242);
    tick(); idle_inputs();
    chk("R6 cleared", int'(coalesce_o), 0);
    wr(32'h9090, 64); wr(32'h90D0, 64);
    chk("R6 count restarted", int'(coalesce_o), 0);

    phase = "R11";
    rst = 1; tick(); rst = 0;
    cur = 0;
    for (int i = 0; i < 8; i++) begin wr(cur, 64); cur += 64; end
    query(2); chk("R11 evicted line 2", int'(dly_hold_o), 0);
    query(3); chk("R11 evicted line 3", int'(dly_hold_o), 0);
    query(4); chk("R11 kept line 4", int'(dly_hold_o), 1);
    query(6); chk("R11 kept line 6", int'(dly_hold_o), 1);

    phase = "R12";
    dq_valid = 1; dq_line = 8; wr(32'h200, 64);
    chk("R12 same-cycle query", int'(dly_hold_o), 0);
    query(8); chk("R12 later query", int'(dly_hold_o), 1);
    phase = "R10";
    dc_valid = 1; dc_line = 9; wr(32'h240, 64);
    query(9); chk("R10 drop beats install", int'(dly_hold_o), 0);

    phase = "R7";
    repeat (5) tick();
    chk("R7 idle allocate", int'(allocate_o), 0);
    chk("R7 idle coalesce", int'(coalesce_o), 1);

    cur = 32'h4000;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      wr_valid = (r < 70);
      if ($urandom_range(0, 9) < 2) cur = cur + 32'($urandom_range(1, 300));
      wr_addr = cur; wr_size = SIZE_W'($urandom_range(1, 64)); wr_line = LINE_W'(cur >> 6);
      if (wr_valid) cur = cur + 32'(wr_size);
      dq_valid = ($urandom_range(0, 2) == 0);
      dq_line = LINE_W'((cur >> 6) - $urandom_range(0, 5));
      dc_valid = ($urandom_range(0, 9) == 0);
      dc_line = LINE_W'((cur >> 6) - $urandom_range(0, 5));
      mode_clr = ($urandom_range(0, 99) == 0);
      tick();
    end
    idle_inputs();
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule